// File: doc/BRIEF.md
# Load-Reserve Reservation Tracker with Paired Quadword Atomics

This block keeps the one reservation that a data cache holds for load-reserve / store-conditional sequences. It watches every request on the cache's request path. A load-reserve records the cache line it touched. A store-conditional is allowed to write only if that reservation is still valid and covers the same line. When a store-conditional is refused, the block raises a cancel signal in the same cycle, so the cache can drop the write. One cycle later it reports a pass/fail status for the whole operation.

A quadword atomic reaches the block as two consecutive requests. Both carry a pair flag, and the second also carries a final-half flag. Only the final half may establish or consume the reservation, so the first half cannot use it up before its partner is checked. If the first half of a paired store-conditional is refused, the refusal is carried over to the second half. The pair then fails as a unit. Requests without the reserve flag pass through untouched. The reservation valid bit and its line address are brought out for observation.

Top module: `rsv_tracker`

## Requirements
- R1: After reset the reservation is invalid and no store-conditional status is reported (rsv_valid = 0, sc_done = 0).
- R2: A load-reserve (req_store = 0, req_reserve = 1) that is unpaired (req_qw = 0) or is the final half of a pair (req_qw = 1, req_last = 1) makes the reservation valid the next cycle, and rsv_line equals req_addr bits 63 down to log2(LINE_BYTES).
- R3: The first half of a paired load-reserve (req_qw = 1, req_last = 0) leaves the reservation valid bit and line unchanged.
- R4: A store-conditional (req_store = 1, req_reserve = 1) made while the reservation is invalid raises cancel_store in the same cycle.
- R5: A store-conditional raises cancel_store when its line address differs from rsv_line. It does not when the lines match and the reservation is valid; address bits inside the line play no part.
- R6: An unpaired or final-half store-conditional invalidates the reservation the next cycle, whether or not it was cancelled.
- R7: The first half of a paired store-conditional leaves the reservation valid bit and line unchanged.
- R8: When the first half of a paired store-conditional is cancelled, the final half is also cancelled, whatever its own address check gives.
- R9: sc_done is high for exactly the cycle after an unpaired or final-half store-conditional and never after a first half. sc_ok in that cycle is 1 only if no half of the operation was cancelled.
- R10: Requests without the reserve flag, and idle cycles, never raise cancel_store and leave the reservation unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_reserve | input | 1 | Reservation semantics (load-reserve or store-conditional) |
| req_addr | input | ADDR_W (64) | Byte address of the request |
| req_qw | input | 1 | Request is one half of a quadword atomic pair |
| req_last | input | 1 | Request is the final half of the pair |
| cancel_store | output | 1 | Refuse the store-conditional presented this cycle |
| sc_done | output | 1 | Store-conditional status valid (one cycle after final request) |
| sc_ok | output | 1 | Store-conditional succeeded |
| rsv_valid | output | 1 | Reservation currently held |
| rsv_line | output | ADDR_W-log2(LINE_BYTES) | Line address of the reservation |

## Verification
The assertions assume well-formed pairs. A paired request with req_last = 0 is followed directly by its final half with the same load/store type and the reserve flag. The pair-chaining check relies on that adjacency. The stimulus always issues paired operations as two back-to-back requests from one task, with the second address eight bytes above a 16-byte-aligned first. Only the directed chaining case gives the two halves different lines, and it keeps the adjacency.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

  typedef enum logic [1:0] {
    K_IDLE  = 2'd0,
    K_PLAIN = 2'd1,
    K_LARX  = 2'd2,
    K_STCX  = 2'd3
  } req_kind_e;

  // Map raw request flags to a request kind.
  function automatic req_kind_e classify(input logic valid, input logic store,
                                         input logic reserve);
    if (!valid)        return K_IDLE;
    else if (!reserve) return K_PLAIN;
    else if (store)    return K_STCX;
    else               return K_LARX;
  endfunction

  // A request may act on the reservation when it is not paired
  // or when it closes a pair.
  function automatic logic acts_on_rsv(input logic qw, input logic last);
    return !qw || last;
  endfunction

endpackage

// File: rtl/rsv_classify.sv
module rsv_classify
  import rsv_pkg::*;
(
  input  logic req_valid,
  input  logic req_store,
  input  logic req_reserve,
  input  logic req_qw,
  input  logic req_last,
  output logic larx_final,
  output logic stcx_any,
  output logic stcx_first,
  output logic stcx_final
);

  req_kind_e kind;
  logic      closes;

  always_comb begin
    kind       = classify(req_valid, req_store, req_reserve);
    closes     = acts_on_rsv(req_qw, req_last);
    larx_final = (kind == K_LARX) && closes;
    stcx_any   = (kind == K_STCX);
    stcx_first = (kind == K_STCX) && !closes;
    stcx_final = (kind == K_STCX) && closes;
  end

endmodule

// File: rtl/rsv_store.sv
module rsv_store #(
  parameter int LINE_W = 58
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic              clr_en,
  input  logic [LINE_W-1:0] set_line,
  output logic              rsv_valid,
  output logic [LINE_W-1:0] rsv_line
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsv_valid <= 1'b0;
      rsv_line  <= '0;
    end else if (set_en) begin
      rsv_valid <= 1'b1;
      rsv_line  <= set_line;
    end else if (clr_en) begin
      rsv_valid <= 1'b0;
    end
  end

  AST_SET_RECORDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> (rsv_valid && rsv_line == $past(set_line))); // R2

  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !set_en) |=> !rsv_valid); // R6

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_en && !clr_en) |=> ($stable(rsv_valid) && $stable(rsv_line))); // R10

endmodule

// File: rtl/rsv_qw_track.sv
module rsv_qw_track (
  input  logic clk,
  input  logic rst_n,
  input  logic stcx_first,
  input  logic stcx_final,
  input  logic first_refused,
  output logic pend_fail
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pend_fail <= 1'b0;
    else if (stcx_first) pend_fail <= first_refused;
    else if (stcx_final) pend_fail <= 1'b0;
  end

  AST_PEND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    stcx_final |=> !pend_fail); // R8

endmodule

// File: rtl/rsv_status.sv
module rsv_status (
  input  logic clk,
  input  logic rst_n,
  input  logic stcx_final,
  input  logic cancel,
  output logic sc_done,
  output logic sc_ok
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_done <= 1'b0;
      sc_ok   <= 1'b0;
    end else begin
      sc_done <= stcx_final;
      sc_ok   <= stcx_final && !cancel;
    end
  end

  AST_STATUS_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (stcx_final && cancel) |=> (sc_done && !sc_ok)); // R9

  AST_NO_STRAY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !stcx_final |=> !sc_done); // R9

endmodule

// File: rtl/rsv_tracker.sv
module rsv_tracker
  import rsv_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int LINE_BYTES = 64,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int LINE_W    = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic              req_reserve,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_qw,
  input  logic              req_last,
  output logic              cancel_store,
  output logic              sc_done,
  output logic              sc_ok,
  output logic              rsv_valid,
  output logic [LINE_W-1:0] rsv_line
);

  // Compare a full address against a stored line; offset bits drop out.
  function automatic logic line_differs(input logic [ADDR_W-1:0] a,
                                        input logic [LINE_W-1:0] line);
    logic [ADDR_W-1:0] diff;
    diff = (a ^ {line, {OFF_W{1'b0}}}) >> OFF_W;
    return diff != '0;
  endfunction

  logic larx_final, stcx_any, stcx_first, stcx_final;
  logic addr_miss, base_fail, pend_fail;
  logic [LINE_W-1:0] req_line;

  rsv_classify u_cls (
    .req_valid  (req_valid),
    .req_store  (req_store),
    .req_reserve(req_reserve),
    .req_qw     (req_qw),
    .req_last   (req_last),
    .larx_final (larx_final),
    .stcx_any   (stcx_any),
    .stcx_first (stcx_first),
    .stcx_final (stcx_final)
  );

  always_comb begin
    req_line     = req_addr[ADDR_W-1:OFF_W];
    addr_miss    = line_differs(req_addr, rsv_line);
    base_fail    = !rsv_valid || addr_miss;
    cancel_store = stcx_any && (base_fail || (stcx_final && pend_fail));
  end

  rsv_store #(.LINE_W(LINE_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (larx_final),
    .clr_en   (stcx_final),
    .set_line (req_line),
    .rsv_valid(rsv_valid),
    .rsv_line (rsv_line)
  );

  rsv_qw_track u_qw (
    .clk          (clk),
    .rst_n        (rst_n),
    .stcx_first   (stcx_first),
    .stcx_final   (stcx_final),
    .first_refused(base_fail),
    .pend_fail    (pend_fail)
  );

  rsv_status u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .stcx_final(stcx_final),
    .cancel    (cancel_store),
    .sc_done   (sc_done),
    .sc_ok     (sc_ok)
  );

  AST_CANCEL_NO_RSV: assert property (@(posedge clk) disable iff (!rst_n)
    (stcx_any && !rsv_valid) |-> cancel_store); // R4

  AST_CANCEL_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (stcx_any && rsv_valid && (req_addr[ADDR_W-1:OFF_W] != rsv_line)) |-> cancel_store); // R5

  AST_QW_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stcx_first && cancel_store) && stcx_final) |-> cancel_store); // R8

  AST_PLAIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid || !req_reserve) |-> !cancel_store); // R10

  AST_FIRST_HALF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_reserve && req_qw && !req_last)
      |=> ($stable(rsv_valid) && $stable(rsv_line))); // R3 R7

endmodule

// File: tb/rsv_tracker_tb.sv
`timescale 1ns/100ps
module rsv_tracker_tb_top;

  localparam int OFF = 6;
  localparam logic [63:0] BASE = 64'h1000_0000_0004_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 0, req_store = 0, req_reserve = 0, req_qw = 0, req_last = 0;
  logic [63:0] req_addr = '0;
  logic        cancel_store, sc_done, sc_ok, rsv_valid;
  logic [57:0] rsv_line;

  always #2.5 clk = ~clk;

  rsv_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_reserve(req_reserve), .req_addr(req_addr), .req_qw(req_qw),
    .req_last(req_last), .cancel_store(cancel_store), .sc_done(sc_done),
    .sc_ok(sc_ok), .rsv_valid(rsv_valid), .rsv_line(rsv_line)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // Bench-side model
  logic        m_valid = 0, m_pend = 0, e_done = 0, e_ok = 0;
  logic [57:0] m_line = '0;
  string       st_tag = "R1";

  function automatic logic [57:0] line_of(input logic [63:0] a);
    return a[63:OFF];
  endfunction

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_state();
    chk(rsv_valid == m_valid, st_tag, "rsv_valid", 64'(rsv_valid), 64'(m_valid));
    if (m_valid)
      chk(rsv_line == m_line, st_tag, "rsv_line", 64'(rsv_line), 64'(m_line));
    chk(sc_done == e_done, (st_tag == "R1") ? "R1" : "R9", "sc_done", 64'(sc_done), 64'(e_done));
    if (e_done)
      chk(sc_ok == e_ok, "R9", "sc_ok", 64'(sc_ok), 64'(e_ok));
  endtask

  task automatic step(input logic v, input logic st, input logic rs,
                      input logic [63:0] a, input logic qw, input logic last);
    logic is_sc, is_lr, fin, base, ec;
    string tag;
    @(negedge clk);
    check_state();
    req_valid = v; req_store = st; req_reserve = rs; req_addr = a;
    req_qw = qw; req_last = last;
    #1;
    is_sc = v && rs && st;
    is_lr = v && rs && !st;
    fin   = !qw || last;
    base  = !m_valid || (line_of(a) != m_line);
    ec    = is_sc && (base || (qw && last && m_pend));
    if (!is_sc)                        tag = "R10";
    else if (qw && last && m_pend)     tag = "R8";
    else if (!m_valid)                 tag = "R4";
    else                               tag = "R5";
    chk(cancel_store == ec, tag, "cancel_store", 64'(cancel_store), 64'(ec));
    e_done = is_sc && fin;
    e_ok   = !ec;
    if (is_lr && fin)       begin m_valid = 1; m_line = line_of(a); st_tag = "R2"; end
    else if (is_lr)         st_tag = "R3";
    else if (is_sc && fin)  begin m_valid = 0; st_tag = "R6"; end
    else if (is_sc)         st_tag = "R7";
    else                    st_tag = "R10";
    if (is_sc && !fin)      m_pend = base;
    else if (is_sc && fin)  m_pend = 0;
  endtask

  task automatic pair(input logic st, input logic [63:0] a16);
    step(1, st, 1, a16, 1, 0);
    step(1, st, 1, a16 + 64'd8, 1, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state checked on first step; then directed cases
    step(0, 0, 0, '0, 0, 0);
    step(1, 1, 1, BASE, 0, 0);                       // R4 SC without reservation
    step(1, 0, 1, BASE + 64'd5, 0, 0);               // R2 set
    step(1, 0, 0, BASE + 64'd128, 0, 0);             // R10 plain load
    step(1, 1, 0, BASE + 64'd192, 0, 0);             // R10 plain store
    step(1, 1, 1, BASE + 64'd63, 0, 0);              // R5 match, offset ignored; R6 clear
    step(1, 0, 1, BASE, 0, 0);
    step(1, 1, 1, BASE + 64'd64, 0, 0);              // R5 miss
    step(1, 0, 1, BASE + 64'd64, 1, 0);              // R3 first half does not set
    step(1, 0, 1, BASE + 64'd72, 1, 1);              // R2 final half sets
    step(1, 1, 1, BASE + 64'd64, 1, 0);              // R7 first half keeps
    step(1, 1, 1, BASE + 64'd72, 1, 1);              // R9 pair success
    step(1, 0, 1, BASE, 0, 0);
    step(1, 1, 1, BASE + 64'd256, 1, 0);             // R8 first half refused
    step(1, 1, 1, BASE + 64'd8, 1, 1);               // R8 final half chained
    step(0, 0, 0, '0, 0, 0);

    // Constrained random
    for (int i = 0; i < 3000; i++) begin
      int unsigned op = $urandom % 7;
      logic [63:0] ln = BASE + 64'(($urandom % 3) * 64);
      case (op)
        0: step(1, 0, 0, ln + 64'($urandom % 64), 0, 0);
        1: step(1, 1, 0, ln + 64'($urandom % 64), 0, 0);
        2: step(1, 0, 1, ln + 64'($urandom % 64), 0, 0);
        3: step(1, 1, 1, ln + 64'($urandom % 64), 0, 0);
        4: pair(0, ln + 64'(($urandom % 4) * 16));
        5: pair(1, ln + 64'(($urandom % 4) * 16));
        default: step(0, 0, 0, '0, 0, 0);
      endcase
    end
    step(0, 0, 0, '0, 0, 0);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    #(100000 * 5);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule